// File: doc/BRIEF.md
# Fixed-Timing Slave Transfer Sequencer

This block sits between the slave side of a synchronous memory-mapped bus and a simple peripheral that needs each access framed by fixed timing. When the master raises its read or write strobe at an address inside the block's decode window, the sequencer opens a transfer. It counts through a setup phase, then a strobe phase. A write then also passes through a hold phase. The stall (wait-request) line to the master stays high until the completing cycle. The peripheral's chip-select, read-enable and write-enable are driven from the cycle count.

The phase lengths are compile-time parameters, set apart for reads and for writes. A read takes RD_SETUP + RD_WAIT + 1 cycles. A write takes WR_SETUP + WR_WAIT + 1 + WR_HOLD cycles. The peripheral address and write data are captured in the first cycle of a transfer and held until it ends. Read data from the peripheral goes to the master in the completing cycle. With every count at zero, each transfer takes one cycle and the master is never stalled.

Top module: `slave_phase_sequencer`

## Requirements
- R1: A strobe whose address fails the decode, that is ((addr ^ DEC_BASE) & DEC_MASK) != 0, is ignored. per_cs, per_rd_en, per_wr_en and bus_stall stay 0, and bus_rdata is 0.
- R2: A decoded read occupies RD_SETUP + RD_WAIT + 1 cycles. bus_stall is high in every one of these cycles except the last.
- R3: A decoded write occupies WR_SETUP + WR_WAIT + WR_HOLD + 1 cycles. bus_stall is high in every one of these cycles except the last.
- R4: Cycles of a transfer are numbered k = 0, 1, ... from its first cycle. per_cs is high in every cycle of a transfer and low outside one. The matching enable (per_rd_en or per_wr_en) is high exactly when SETUP <= k <= SETUP + WAIT, using the counts for that kind of transfer.
- R5: In the WR_HOLD cycles that follow the write strobe, per_cs stays high, per_wr_en is low, and per_addr and per_wdata keep the values of the transfer.
- R6: bus_rdata equals per_rdata in the completing cycle of a read, and is 0 in every other cycle.
- R7: per_addr and per_wdata carry the bus address and write data of cycle k = 0 throughout the transfer, even if the bus values change while the master is stalled.
- R8: With all counts at zero, every decoded read or write completes in the cycle it is presented. bus_stall is never high, and the enable is high in that same cycle.
- R9: A strobe still held in the cycle after a transfer completes starts a new transfer at k = 0. No new transfer begins before the hold phase of a write has ended.
- R10: When bus_rd and bus_wr are both high at a decoded address, the transfer is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address from master |
| bus_rd | input | 1 | Read strobe from master |
| bus_wr | input | 1 | Write strobe from master |
| bus_wdata | input | DATA_W | Write data from master |
| bus_rdata | output | DATA_W | Read data to master |
| bus_stall | output | 1 | Wait-request to master |
| per_cs | output | 1 | Peripheral chip-select |
| per_rd_en | output | 1 | Peripheral read enable |
| per_wr_en | output | 1 | Peripheral write enable |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | DATA_W | Peripheral read data |

## Verification
The bench runs every address of a 4-bit space through reads, writes and combined strobes, and checks every output in every cycle against phase arithmetic. This catches three kinds of fault. A decoder that is off would select addresses outside the window. A miscounted phase would drop or add a stall cycle. A strobe window that is off by one would end the write enable inside the hold cycle.

While the master is stalled, the bench scrambles the bus address and data. A design that passes them straight through instead of capturing them would corrupt the hold cycle. The bench also holds the strobe across a completion, presents both strobes together, and drives a second instance with all counts at zero. These tests expose a sequencer that fails to restart, that gives reads priority, or that inserts a stall it should not.

// File: rtl/sts_pkg.sv
// Shared types for the fixed-timing slave sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package sts_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/sts_addr_match.sv
// Address window decoder: hit when the masked address bits equal the base.
// Assumes base and mask are static parameters.
module sts_addr_match #(
    parameter int ADDR_W   = 4,
    parameter int DEC_BASE = 8,
    parameter int DEC_MASK = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_C = ADDR_W'(DEC_BASE);
    localparam logic [ADDR_W-1:0] MASK_C = ADDR_W'(DEC_MASK);

    // Compare only the bits the mask selects.
    always_comb begin
        hit = (((addr ^ BASE_C) & MASK_C) == '0);
    end
endmodule

// File: rtl/sts_phase_counter.sv
// Transfer cycle counter. It opens a transfer on a decoded request, counts
// the cycle index k and flags the completing cycle.
// Assumes the master holds its strobe while stalled (the bus rule).
module sts_phase_counter #(
    parameter int CNT_W   = 2,
    parameter int RD_LAST = 2,
    parameter int WR_LAST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    output logic             active,
    output logic             busy,
    output logic             cur_wr,
    output logic [CNT_W-1:0] k,
    output logic             last_cycle
);
    localparam logic [CNT_W-1:0] RD_LAST_C = CNT_W'(RD_LAST);
    localparam logic [CNT_W-1:0] WR_LAST_C = CNT_W'(WR_LAST);

    logic [CNT_W-1:0] cnt_q;
    logic             wr_q;
    logic [CNT_W-1:0] last_k;

    // Current cycle view: registered while active, otherwise a fresh start.
    always_comb begin
        busy       = active | req;
        k          = active ? cnt_q : '0;
        cur_wr     = active ? wr_q : req_wr;
        last_k     = cur_wr ? WR_LAST_C : RD_LAST_C;
        last_cycle = busy && (k == last_k);
    end

    // Advance the count, or return to idle after the completing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
            wr_q   <= 1'b0;
        end else if (busy && !last_cycle) begin
            active <= 1'b1;
            cnt_q  <= k + 1'b1;
            wr_q   <= cur_wr;
        end else begin
            active <= 1'b0;
            cnt_q  <= '0;
        end
    end

    // R2/R3: the count never runs past the completing cycle of its kind.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= (wr_q ? WR_LAST_C : RD_LAST_C)));
    // R9: the cycle after a completion is never a continuation.
    a_r9_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_cycle |=> !active);
endmodule

// File: rtl/sts_strobe_gen.sv
// Peripheral strobe and stall generator driven by the cycle index.
// Assumes k, busy and cur_wr come from sts_phase_counter.
module sts_strobe_gen
    import sts_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int RD_SETUP = 1,
    parameter int RD_WAIT  = 1,
    parameter int WR_SETUP = 1,
    parameter int WR_WAIT  = 0
) (
    input  logic             busy,
    input  logic             cur_wr,
    input  logic [CNT_W-1:0] k,
    input  logic             last_cycle,
    output phase_e           phase,
    output logic             cs,
    output logic             rd_en,
    output logic             wr_en,
    output logic             stall
);
    localparam logic [CNT_W-1:0] RD_S_C = CNT_W'(RD_SETUP);
    localparam logic [CNT_W-1:0] RD_E_C = CNT_W'(RD_SETUP + RD_WAIT);
    localparam logic [CNT_W-1:0] WR_S_C = CNT_W'(WR_SETUP);
    localparam logic [CNT_W-1:0] WR_E_C = CNT_W'(WR_SETUP + WR_WAIT);

    logic [CNT_W-1:0] s_k;
    logic [CNT_W-1:0] e_k;
    logic             in_strobe;

    // Classify the current cycle into a phase and derive outputs.
    always_comb begin
        s_k       = cur_wr ? WR_S_C : RD_S_C;
        e_k       = cur_wr ? WR_E_C : RD_E_C;
        in_strobe = busy && (k >= s_k) && (k <= e_k);
        if (!busy)          phase = PH_IDLE;
        else if (k < s_k)   phase = PH_SETUP;
        else if (in_strobe) phase = PH_STROBE;
        else                phase = PH_HOLD;
        cs    = busy;
        rd_en = in_strobe && !cur_wr;
        wr_en = in_strobe && cur_wr;
        stall = busy && !last_cycle;
    end
endmodule

// File: rtl/sts_datapath.sv
// Captures address and write data at transfer start and gates read data
// to the master. Assumes start is high only in cycle k = 0.
module sts_datapath #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Latch the first-cycle address and data of each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= bus_addr;
            wdata_q <= bus_wdata;
        end
    end

    // Pass through in cycle 0, replay the capture afterwards; gate read data.
    always_comb begin
        per_addr  = active ? addr_q  : bus_addr;
        per_wdata = active ? wdata_q : bus_wdata;
        bus_rdata = rd_done ? per_rdata : '0;
    end

    // R7: the peripheral address holds once a transfer is under way.
    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> $stable(per_addr));
endmodule

// File: rtl/slave_phase_sequencer.sv
// Top of the fixed-timing slave sequencer. It decodes the address, counts
// the transfer phases, drives the peripheral strobes and the master stall.
// Assumes the master keeps its strobe asserted while bus_stall is high.
module slave_phase_sequencer
    import sts_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int DEC_BASE = 8,
    parameter int DEC_MASK = 12,
    parameter int RD_SETUP = 1,
    parameter int RD_WAIT  = 1,
    parameter int WR_SETUP = 1,
    parameter int WR_WAIT  = 0,
    parameter int WR_HOLD  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_stall,
    output logic              per_cs,
    output logic              per_rd_en,
    output logic              per_wr_en,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata
);
    localparam int RD_LAST = RD_SETUP + RD_WAIT;
    localparam int WR_LAST = WR_SETUP + WR_WAIT + WR_HOLD;
    localparam int MAX_LAST = (WR_LAST > RD_LAST) ? WR_LAST : RD_LAST;
    localparam int CNT_W = (MAX_LAST < 1) ? 1 : $clog2(MAX_LAST + 1);

    logic             hit;
    logic             req;
    logic             req_wr;
    logic             active;
    logic             busy;
    logic             cur_wr;
    logic [CNT_W-1:0] k;
    logic             last_cycle;
    logic             start;
    logic             rd_done;
    phase_e           phase;

    sts_addr_match #(
        .ADDR_W(ADDR_W), .DEC_BASE(DEC_BASE), .DEC_MASK(DEC_MASK)
    ) u_match (
        .addr(bus_addr), .hit(hit)
    );

    // Qualify strobes with the decode; a write wins over a read.
    always_comb begin
        req     = (bus_rd | bus_wr) & hit;
        req_wr  = bus_wr & hit;
        start   = req && !active;
        rd_done = last_cycle && !cur_wr;
    end

    sts_phase_counter #(
        .CNT_W(CNT_W), .RD_LAST(RD_LAST), .WR_LAST(WR_LAST)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .active(active), .busy(busy), .cur_wr(cur_wr), .k(k),
        .last_cycle(last_cycle)
    );

    sts_strobe_gen #(
        .CNT_W(CNT_W), .RD_SETUP(RD_SETUP), .RD_WAIT(RD_WAIT),
        .WR_SETUP(WR_SETUP), .WR_WAIT(WR_WAIT)
    ) u_strb (
        .busy(busy), .cur_wr(cur_wr), .k(k), .last_cycle(last_cycle),
        .phase(phase), .cs(per_cs), .rd_en(per_rd_en), .wr_en(per_wr_en),
        .stall(bus_stall)
    );

    sts_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .start(start), .active(active),
        .rd_done(rd_done), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .per_rdata(per_rdata), .per_addr(per_addr), .per_wdata(per_wdata),
        .bus_rdata(bus_rdata)
    );

    // R4: an enable is only ever raised under chip-select.
    a_r4_en_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd_en || per_wr_en) |-> per_cs);
    // R10: read and write enables never overlap.
    a_r10_en_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(per_rd_en && per_wr_en));
    // R5: the hold phase keeps the select with no strobe.
    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> (per_cs && !per_wr_en && !per_rd_en));
    // R2/R3: a stalled master always faces an open transfer.
    a_r2_stall_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stall |-> per_cs);
    // R6: read data shows only when the stall has dropped.
    a_r6_rdata_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != '0) |-> !bus_stall);
endmodule

// File: tb/slave_phase_sequencer_tb_top.sv
// Sweeps every address through reads, writes and combined strobes on a
// 1/1 read, 1/0/1 write configuration, plus a zero-count instance.
module slave_phase_sequencer_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int RS = 1, RW = 1, WS = 1, WW = 0, WH = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata, per_wdata, per_rdata;
    logic [AW-1:0] per_addr;
    logic bus_stall, per_cs, per_rd_en, per_wr_en;

    logic [AW-1:0] z_addr = '0;
    logic z_rd = 1'b0, z_wr = 1'b0;
    logic [DW-1:0] z_wdata = '0;
    logic [DW-1:0] z_rdata, z_pwdata, z_prdata;
    logic [AW-1:0] z_paddr;
    logic z_stall, z_cs, z_rden, z_wren;

    // Peripheral model: read data is a function of its address.
    assign per_rdata = {per_addr, ~per_addr};
    assign z_prdata  = {z_paddr, ~z_paddr};

    slave_phase_sequencer #(
        .ADDR_W(AW), .DATA_W(DW), .DEC_BASE(8), .DEC_MASK(12),
        .RD_SETUP(RS), .RD_WAIT(RW), .WR_SETUP(WS), .WR_WAIT(WW), .WR_HOLD(WH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_stall(bus_stall), .per_cs(per_cs), .per_rd_en(per_rd_en),
        .per_wr_en(per_wr_en), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata)
    );

    slave_phase_sequencer #(
        .ADDR_W(AW), .DATA_W(DW), .DEC_BASE(0), .DEC_MASK(0),
        .RD_SETUP(0), .RD_WAIT(0), .WR_SETUP(0), .WR_WAIT(0), .WR_HOLD(0)
    ) dut_z_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(z_addr), .bus_rd(z_rd),
        .bus_wr(z_wr), .bus_wdata(z_wdata), .bus_rdata(z_rdata),
        .bus_stall(z_stall), .per_cs(z_cs), .per_rd_en(z_rden),
        .per_wr_en(z_wren), .per_addr(z_paddr), .per_wdata(z_pwdata),
        .per_rdata(z_prdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One transfer from cycle 0 to completion, checked each cycle.
    task automatic xfer(input bit wr, input bit rd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        bit hit = (a[3:2] == 2'b10);
        bit iw = wr;
        int s = iw ? WS : RS;
        int e = iw ? WS + WW : RS + RW;
        int last = hit ? (iw ? WS + WW + WH : RS + RW) : 0;
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
        for (int k = 0; k <= last; k++) begin
            bit en;
            #1;
            en = hit && k >= s && k <= e;
            chk(hit ? "R4 cs" : "R1 cs", per_cs, hit);
            chk(iw ? "R3 stall" : "R2 stall", bus_stall, hit && k < last);
            chk(iw ? "R4 wr_en" : "R4 rd_en", iw ? per_wr_en : per_rd_en, en);
            chk(iw ? "R10 rd_en off" : "R4 wr_en off", iw ? per_rd_en : per_wr_en, 0);
            if (hit) chk("R7 addr", per_addr, a);
            if (hit && iw) chk(k > e ? "R5 hold data" : "R7 data", per_wdata, d);
            chk(hit ? "R6 rdata" : "R1 rdata", bus_rdata,
                (hit && !iw && k == last) ? {a, ~a} : 8'h00);
            @(negedge clk);
            if (k < last) begin bus_addr = ~a; bus_wdata = ~d; end
        end
        bus_wr = 0; bus_rd = 0;
        #1;
        chk("R9 idle after", {per_cs, bus_stall}, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R4 reset cs", per_cs, 0);
        chk("R2 reset stall", bus_stall, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            xfer(0, 1, a[AW-1:0], 8'h00);
            xfer(1, 0, a[AW-1:0], 8'h3C ^ a[7:0]);
            xfer(1, 1, a[AW-1:0], 8'hA5 ^ a[7:0]);
        end
        // R9: write strobe held across completion restarts at k = 0.
        bus_addr = 4'h9; bus_wdata = 8'h55; bus_wr = 1;
        repeat (WS + WW + WH + 1) @(negedge clk);
        #1;
        chk("R9 restart stall", bus_stall, 1);
        chk("R9 restart setup", per_wr_en, 0);
        chk("R9 restart cs", per_cs, 1);
        @(negedge clk);
        #1;
        chk("R9 restart strobe", per_wr_en, 1);
        repeat (WH + 1) @(negedge clk);
        bus_wr = 0;
        @(negedge clk);
        // R8: zero counts, back-to-back single-cycle transfers.
        for (int i = 0; i < 8; i++) begin
            z_addr = i[AW-1:0]; z_wdata = 8'h10 + i[7:0];
            z_wr = i[0]; z_rd = ~i[0];
            #1;
            chk("R8 no stall", z_stall, 0);
            chk("R8 enable", i[0] ? z_wren : z_rden, 1);
            chk("R8 data", i[0] ? z_pwdata : z_rdata,
                i[0] ? 8'h10 + i[7:0] : {i[3:0], ~i[3:0]});
            @(negedge clk);
        end
        z_wr = 0; z_rd = 0;
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule